// File: doc/BRIEF.md
# Serial Four-Channel Volume Register Block

This block is the digital side of a four-channel audio volume controller. A host microcontroller drives two wires, a serial clock and a serial data line. The block brings both wires into its own faster system clock and shifts in 16-bit control words, first bit first. A word takes effect only when the data line is high at a falling serial-clock edge after all sixteen bits have arrived. The two last bits of the word pick one of four register groups: trim levels for the left and right channels, trim levels for the center and subwoofer channels together with the subwoofer output gain, master levels for left and right, or master levels for center and subwoofer.

For each channel the block adds the 1 dB-step trim level to the decoded master level and reports the total attenuation as a 7-bit magnitude in dB. The total is held at 87 dB. The top master code mutes the channel. The subwoofer output gain code is passed straight through to the analog side.

Top module: `serial_vol_regs`

## Requirements
- R1: While the synchronous reset is high, and after it is released, every trim, master and gain field is code 0. All four attenuation outputs read 0, all mute flags read 0 and the gain output reads 00.
- R2: Bits are taken from the data line at rising serial-clock edges, D0 first, up to 16 per word. Rising edges that come after the sixteenth bit and before a latch capture nothing.
- R3: A falling serial-clock edge with the data line high, once 16 bits are held, transfers the word. The outputs show it in the system cycle after the edge is detected, and the bit count starts again from zero.
- R4: A falling edge with the data line high before 16 bits are held is ignored. Outputs do not change and the bit count keeps running, so the bits that follow complete the same word.
- R5: The selector is {D14,D15}. 00 writes left and right trim, 01 writes center and sub trim plus the gain, 10 writes left and right master, and 11 writes center and sub master. Groups that are not selected keep their values.
- R6: A trim field is 4 bits, with D0 (first channel) or D4 (second channel) as the MSB. The code value is the attenuation in dB, 0 to 15.
- R7: A master field is 5 bits, D0..D4 for the first channel and D5..D9 for the second, with the first bit as the MSB. Codes 0..22 give 2 dB per step (0..44 dB). Codes 23..30 give 48..76 dB in 4 dB steps.
- R8: The attenuation output equals trim plus master in dB, held at 87 when the sum exceeds 87. For example, 15 plus 76 reads 87 and 14 plus 72 reads 86.
- R9: Master code 31 sets the channel's mute flag and forces its attenuation output to 87, whatever the trim value.
- R10: The gain output is {D9,D10} of a selector-01 word: 00 means 0 dB, 01 means +6 dB, 10 means +9 dB and 11 means +12 dB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high, models power-up |
| ser_clk | input | 1 | Host serial clock, asynchronous |
| ser_dat | input | 1 | Host serial data, asynchronous |
| att_left | output | 7 | Left channel attenuation in dB |
| att_right | output | 7 | Right channel attenuation in dB |
| att_center | output | 7 | Center channel attenuation in dB |
| att_sub | output | 7 | Subwoofer channel attenuation in dB |
| mute_left | output | 1 | Left channel muted |
| mute_right | output | 1 | Right channel muted |
| mute_center | output | 1 | Center channel muted |
| mute_sub | output | 1 | Subwoofer channel muted |
| sub_gain | output | 2 | Subwoofer output gain code |

## Verification
The bench builds the block with its default parameters: a 16-bit word, two synchroniser stages and an 87 dB ceiling. With these values the full master code range and the trim range can be combined, so sums just below, exactly at and above the ceiling (86, 87, 91) can all be reached. The serial wires are held still for several system cycles per edge so that the two-stage synchroniser always resolves each edge. A premature latch is placed at mid-word to show that the bit count carries on.

// File: rtl/serial_vol_regs.sv
module serial_vol_regs #(
  parameter int WORD_BITS   = 16,
  parameter int SYNC_STAGES = 2,
  parameter int TRIM_W      = 4,
  parameter int MAST_W      = 5,
  parameter int ATT_W       = 7,
  parameter int ATT_LIMIT   = 87,
  parameter int LIN_LAST    = 22,
  parameter int FINE_STEP   = 2,
  parameter int COARSE_STEP = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_clk,
  input  logic             ser_dat,
  output logic [ATT_W-1:0] att_left,
  output logic [ATT_W-1:0] att_right,
  output logic [ATT_W-1:0] att_center,
  output logic [ATT_W-1:0] att_sub,
  output logic             mute_left,
  output logic             mute_right,
  output logic             mute_center,
  output logic             mute_sub,
  output logic [1:0]       sub_gain
);

  localparam int CNT_W     = $clog2(WORD_BITS + 1);
  localparam int IDX_W     = $clog2(WORD_BITS);
  localparam int MUTE_CODE = (1 << MAST_W) - 1;
  localparam int LIN_TOP   = LIN_LAST * FINE_STEP;
  localparam int GAIN_POS  = 2 * TRIM_W + 1;
  localparam logic [1:0] FMT_TRIM_A = 2'b00;
  localparam logic [1:0] FMT_TRIM_B = 2'b01;
  localparam logic [1:0] FMT_MAST_A = 2'b10;
  localparam logic [1:0] FMT_MAST_B = 2'b11;

  logic [SYNC_STAGES-1:0] ck_sync, dt_sync;
  logic                   ck_prev;
  logic                   ck_now, dt_now, ck_rise, ck_fall, full, latch;
  logic [CNT_W-1:0]       bit_cnt;
  logic [WORD_BITS-1:0]   word_q;
  logic [1:0]             sel;
  logic [TRIM_W-1:0]      trim_q [4];
  logic [MAST_W-1:0]      mast_q [4];
  logic [1:0]             gain_q;
  logic [ATT_W-1:0]       att_v  [4];
  logic                   mute_v [4];

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_sync <= '0;
      dt_sync <= '0;
      ck_prev <= 1'b0;
    end else begin
      ck_sync <= {ck_sync[SYNC_STAGES-2:0], ser_clk};
      dt_sync <= {dt_sync[SYNC_STAGES-2:0], ser_dat};
      ck_prev <= ck_now;
    end
  end

  assign ck_now  = ck_sync[SYNC_STAGES-1];
  assign dt_now  = dt_sync[SYNC_STAGES-1];
  assign ck_rise = ck_now & ~ck_prev;
  assign ck_fall = ~ck_now & ck_prev;
  assign full    = (bit_cnt == CNT_W'(WORD_BITS));
  assign latch   = ck_fall & dt_now & full;
  assign sel     = {word_q[WORD_BITS-2], word_q[WORD_BITS-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt <= '0;
      word_q  <= '0;
    end else if (latch) begin
      bit_cnt <= '0;
    end else if (ck_rise && !full) begin
      word_q[bit_cnt[IDX_W-1:0]] <= dt_now;
      bit_cnt <= bit_cnt + 1'b1;
    end
  end

  function automatic logic [TRIM_W-1:0] trim_field(input logic [WORD_BITS-1:0] w, input int base);
    logic [TRIM_W-1:0] f;
    for (int k = 0; k < TRIM_W; k++) f[TRIM_W-1-k] = w[base+k];
    return f;
  endfunction

  function automatic logic [MAST_W-1:0] mast_field(input logic [WORD_BITS-1:0] w, input int base);
    logic [MAST_W-1:0] f;
    for (int k = 0; k < MAST_W; k++) f[MAST_W-1-k] = w[base+k];
    return f;
  endfunction

  function automatic logic [ATT_W-1:0] mast_db(input logic [MAST_W-1:0] code);
    int c;
    c = int'(code);
    if (c <= LIN_LAST) return ATT_W'(c * FINE_STEP);
    return ATT_W'(LIN_TOP + (c - LIN_LAST) * COARSE_STEP);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) begin
        trim_q[i] <= '0;
        mast_q[i] <= '0;
      end
      gain_q <= '0;
    end else if (latch) begin
      case (sel)
        FMT_TRIM_A: begin
          trim_q[0] <= trim_field(word_q, 0);
          trim_q[1] <= trim_field(word_q, TRIM_W);
        end
        FMT_TRIM_B: begin
          trim_q[2] <= trim_field(word_q, 0);
          trim_q[3] <= trim_field(word_q, TRIM_W);
          gain_q    <= {word_q[GAIN_POS], word_q[GAIN_POS+1]};
        end
        FMT_MAST_A: begin
          mast_q[0] <= mast_field(word_q, 0);
          mast_q[1] <= mast_field(word_q, MAST_W);
        end
        default: begin
          mast_q[2] <= mast_field(word_q, 0);
          mast_q[3] <= mast_field(word_q, MAST_W);
        end
      endcase
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_ch
    logic [ATT_W:0] sum;
    assign sum       = {1'b0, mast_db(mast_q[g])} + (ATT_W+1)'(trim_q[g]);
    assign mute_v[g] = (mast_q[g] == MAST_W'(MUTE_CODE));
    assign att_v[g]  = (mute_v[g] || sum > (ATT_W+1)'(ATT_LIMIT)) ? ATT_W'(ATT_LIMIT) : sum[ATT_W-1:0];

    // R8
    att_cap_chk: assert property (@(posedge clk) disable iff (rst)
      att_v[g] <= ATT_W'(ATT_LIMIT));
    // R9
    mute_att_chk: assert property (@(posedge clk) disable iff (rst)
      mute_v[g] |-> att_v[g] == ATT_W'(ATT_LIMIT));
    // R4
    hold_chk: assert property (@(posedge clk) disable iff (rst)
      !latch |=> $stable(trim_q[g]) && $stable(mast_q[g]));
    // R1
    reset_chk: assert property (@(posedge clk)
      rst |=> att_v[g] == '0 && !mute_v[g]);
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CNT_W'(WORD_BITS));
  // R3
  cnt_restart_chk: assert property (@(posedge clk) disable iff (rst)
    latch |=> bit_cnt == '0);
  // R10
  gain_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(latch && sel == FMT_TRIM_B) |=> $stable(gain_q));

  assign att_left    = att_v[0];
  assign att_right   = att_v[1];
  assign att_center  = att_v[2];
  assign att_sub     = att_v[3];
  assign mute_left   = mute_v[0];
  assign mute_right  = mute_v[1];
  assign mute_center = mute_v[2];
  assign mute_sub    = mute_v[3];
  assign sub_gain    = gain_q;

endmodule

// File: tb/sim_serial_vol_regs.sv
module sim_serial_vol_regs;
  logic clk = 0, rst = 1, ser_clk = 0, ser_dat = 0;
  logic [6:0] att_left, att_right, att_center, att_sub;
  logic mute_left, mute_right, mute_center, mute_sub;
  logic [1:0] sub_gain;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  serial_vol_regs u0 (.clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .att_left(att_left), .att_right(att_right), .att_center(att_center), .att_sub(att_sub),
    .mute_left(mute_left), .mute_right(mute_right), .mute_center(mute_center),
    .mute_sub(mute_sub), .sub_gain(sub_gain));

  // word written D0..D15 left to right, channel, expected attenuation, expected mute
  localparam logic [25:0] VEC [12] = '{
    {16'b0101_0011_000000_00, 2'd0, 7'd5,  1'b0},  // R6 trim left 5
    {16'b10110_10111_0000_10, 2'd0, 7'd49, 1'b0},  // R7 code 22 -> 44
    {16'b10110_10111_0000_10, 2'd1, 7'd51, 1'b0},  // R7 code 23 -> 48
    {16'b11110_11111_0000_11, 2'd2, 7'd76, 1'b0},  // R7 code 30 -> 76
    {16'b11110_11111_0000_11, 2'd3, 7'd87, 1'b1},  // R9 mute
    {16'b1111_0000_0_10_000_01, 2'd2, 7'd87, 1'b0}, // R8 91 held at 87
    {16'b00000_00001_0000_10, 2'd1, 7'd5,  1'b0},  // R7 code 1
    {16'b1111_1111_000000_00, 2'd0, 7'd15, 1'b0},  // R6 trim 15
    {16'b11101_11111_0000_10, 2'd0, 7'd87, 1'b0},  // R8 exactly 87
    {16'b1110_1111_000000_00, 2'd0, 7'd86, 1'b0},  // R8 86
    {16'b11111_11111_0000_10, 2'd0, 7'd87, 1'b1},  // R9 trim ignored
    {16'b0000_0111_0_01_000_01, 2'd2, 7'd76, 1'b0}  // R5 center trim 0
  };

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic send_bit(input logic b);
    ser_dat = b; wait_clk(4);
    ser_clk = 1; wait_clk(4);
    ser_dat = 0; wait_clk(4);
    ser_clk = 0; wait_clk(4);
  endtask

  task automatic latch_pulse();
    ser_dat = 1; wait_clk(4);
    ser_clk = 1; wait_clk(4);
    ser_clk = 0; wait_clk(4);
    ser_dat = 0; wait_clk(4);
  endtask

  task automatic send_word(input logic [15:0] w);
    for (int i = 0; i < 16; i++) send_bit(w[15-i]);
    latch_pulse();
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int att_of(input int ch);
    case (ch)
      0: return int'(att_left);
      1: return int'(att_right);
      2: return int'(att_center);
      default: return int'(att_sub);
    endcase
  endfunction

  function automatic int mute_of(input int ch);
    case (ch)
      0: return int'(mute_left);
      1: return int'(mute_right);
      2: return int'(mute_center);
      default: return int'(mute_sub);
    endcase
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    wait_clk(150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    wait_clk(5);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    for (int c = 0; c < 4; c++) begin
      check("R1 att", att_of(c), 0);
      check("R1 mute", mute_of(c), 0);
    end
    check("R1 gain", int'(sub_gain), 0);

    for (int v = 0; v < 12; v++) begin
      send_word(VEC[v][25:10]);
      @(negedge clk);
      check($sformatf("R3 vec%0d att", v), att_of(int'(VEC[v][9:8])), int'(VEC[v][7:1]));
      check($sformatf("R5 vec%0d mute", v), mute_of(int'(VEC[v][9:8])), int'(VEC[v][0]));
    end
    check("R10 gain +6", int'(sub_gain), 1);
    check("R9 left mute", int'(mute_left), 1);

    // R10 gain 11 and R5 other groups untouched
    send_word(16'b0000_0000_0_11_000_01);
    @(negedge clk);
    check("R10 gain +12", int'(sub_gain), 3);
    check("R5 left held", att_of(0), 87);
    check("R5 right held", att_of(1), 87);

    // clear left/right master to code 0
    send_word(16'b00000_00000_0000_10);
    @(negedge clk);
    check("R7 code 0", att_of(0), 14);

    // R4 premature latch after 8 bits, pulse itself carries D8=1
    begin
      logic [15:0] w;
      w = 16'b1001_0010_1_00000_00;
      for (int i = 0; i < 8; i++) send_bit(w[15-i]);
      latch_pulse();
      @(negedge clk);
      check("R4 early latch ignored", att_of(0), 14);
      check("R4 early latch right", att_of(1), 15);
      for (int i = 9; i < 16; i++) send_bit(w[15-i]);
      latch_pulse();
      @(negedge clk);
      check("R4 count kept left", att_of(0), 9);
      check("R2 bit order right", att_of(1), 2);
    end

    // R3 counter restarted: a fresh word lands aligned
    send_word(16'b0011_1100_000000_00);
    @(negedge clk);
    check("R3 restart left", att_of(0), 3);
    check("R6 D4 msb right", att_of(1), 12);

    // R1 reset again clears everything
    rst = 1; wait_clk(3); rst = 0;
    @(negedge clk);
    check("R1 rerun left", att_of(0), 0);
    check("R1 rerun sub mute", mute_of(3), 0);
    check("R1 rerun gain", int'(sub_gain), 0);
    finish_run();
  end
endmodule